// File: doc/BRIEF.md
# Page-Zero Internal Memory Decoder

This block answers every access a processor makes to the lowest 128 bytes of its 13-bit, 8192-byte address space. It holds two 8-bit bidirectional ports, each with a data register and a direction register. It holds 112 bytes of general RAM and a stack pointer confined to the upper 64 bytes of that RAM. It also gives a two-register window, for data and control, onto an external timer. For each address it decides whether the location is internal or external. External accesses raise a bus enable, and the read data is then taken from the external input bus.

The window has holes. Offsets 2, 3, 6, 7 and 10 to 15 are inside page zero but belong to external memory. Writes happen on the rising clock edge while the write strobe is high. Reads are combinational from address to data.

Every access completes in the cycle it is presented, so the interface is a plain strobe bus. There is no valid/ready handshake and no back-pressure: the processor may present a new address on every cycle.

Top module: `pz_decoder`

## Requirements
- R1: `ext_en` is 0 exactly when `cpu_addr[12:7]` is zero and the offset `cpu_addr[6:0]` is 0, 1, 4, 5, 8, 9 or in 16..127. For every other address it is 1.
- R2: While `ext_en` is 1, `cpu_rdata` equals `ext_rdata`.
- R3: On a read of any internal location, `cpu_rdata` is the value of that location, whatever `ext_rdata` carries.
- R4: A write to offset 0 loads port A's data register and a write to offset 1 loads port B's. The register value appears on `pa_pin_out` / `pb_pin_out` after the clock edge.
- R5: Offsets 4 (port A) and 5 (port B) are the direction registers. They are written on the clock edge and read back unchanged, and each bit drives the matching `*_pin_oe` bit, where 1 means output.
- R6: A read of a port data offset returns the register bit where the direction bit is 1, and the live `*_pin_in` bit where it is 0.
- R7: After reset, both direction registers and both data registers are zero, so all pins are inputs.
- R8: At offsets 8 and 9, `tmr_sel` is 1 and `tmr_reg` equals the address bit 0 (0 means data, 1 means control). `tmr_wr` follows `cpu_wr`, and a read returns `tmr_rdata`. At every other address, `tmr_sel` and `tmr_wr` are 0.
- R9: Offsets 16..127 are read/write RAM, and each byte reads back the last value written to it.
- R10: A write to an address with `ext_en` at 1 changes no port register and no RAM byte.
- R11: `stack_ptr` is 0x7F after reset. `sp_push` alone decrements it and `sp_pop` alone increments it. Both together, or neither, hold it. It stays within 0x40..0x7F: a push at 0x40 gives 0x7F and a pop at 0x7F gives 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 13 | Processor address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data, also forwarded to the timer |
| cpu_rdata | output | 8 | Read data |
| ext_en | output | 1 | External memory enable |
| ext_rdata | input | 8 | External read bus |
| tmr_sel | output | 1 | Timer window selected |
| tmr_reg | output | 1 | Timer register select, 0 data, 1 control |
| tmr_wr | output | 1 | Timer write strobe |
| tmr_wdata | output | 8 | Timer write data |
| tmr_rdata | input | 8 | Timer read data |
| pa_pin_in | input | 8 | Port A pin levels |
| pa_pin_out | output | 8 | Port A output values |
| pa_pin_oe | output | 8 | Port A output enables |
| pb_pin_in | input | 8 | Port B pin levels |
| pb_pin_out | output | 8 | Port B output values |
| pb_pin_oe | output | 8 | Port B output enables |
| sp_push | input | 1 | Stack push, decrement |
| sp_pop | input | 1 | Stack pop, increment |
| stack_ptr | output | 7 | Stack pointer |

## Verification
The checker watches several behaviours on every cycle:
- the external read pass-through whenever the enable is high;
- that every address above page zero is external;
- that a timer strobe appears only on an internal timer write;
- that external writes leave the port outputs unchanged;
- the stack pointer's range and its step on a lone push.

Other behaviours only the bench scenarios can show. These are the exact hole pattern across addresses 0..255, read-back of the port, direction and RAM values, and the per-bit mixing of register and pin levels. The same holds for an internal read that returns its own value while the external bus drives a conflicting one, and for the wrap of the stack pointer at both ends.

// File: rtl/pz_pkg.sv
package pz_pkg;
  typedef enum logic [2:0] {
    RG_EXT   = 3'd0,
    RG_PDATA = 3'd1,
    RG_PDDR  = 3'd2,
    RG_TMR   = 3'd3,
    RG_RAM   = 3'd4
  } region_e;
endpackage

// File: rtl/pz_addr_decode.sv
module pz_addr_decode
  import pz_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 128,
  parameter int RAM_BASE   = 16
) (
  input  logic [ADDR_W-1:0]             addr,
  output region_e                       region,
  output logic                          ext_en,
  output logic                          sub,
  output logic [$clog2(PAGE_BYTES)-1:0] off
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic page_hit;

  assign off      = addr[OFF_W-1:0];
  assign sub      = addr[0];
  assign page_hit = (addr[ADDR_W-1:OFF_W] == '0);

  always_comb begin
    region = RG_EXT;
    if (page_hit) begin
      if (int'(off) >= RAM_BASE) begin
        region = RG_RAM;
      end else begin
        case (off[3:0])
          4'd0, 4'd1: region = RG_PDATA;
          4'd4, 4'd5: region = RG_PDDR;
          4'd8, 4'd9: region = RG_TMR;
          default:    region = RG_EXT;
        endcase
      end
    end
  end

  assign ext_en = (region == RG_EXT);
endmodule

// File: rtl/pz_port.sv
module pz_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         wr_dr,
  input  logic         wr_ddr,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] ddr_q
);
  logic [W-1:0] dr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q  <= '0;
      ddr_q <= '0;
    end else begin
      if (wr_dr)  dr_q  <= wdata;
      if (wr_ddr) ddr_q <= wdata;
    end
  end

  assign pin_out = dr_q;
  assign pin_oe  = ddr_q;
  assign rd_data = (ddr_q & dr_q) | (~ddr_q & pin_in);
endmodule

// File: rtl/pz_ram.sv
module pz_ram #(
  parameter int W         = 8,
  parameter int OFF_W     = 7,
  parameter int RAM_BASE  = 16,
  parameter int RAM_BYTES = 112
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFF_W-1:0] off,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);
  logic [W-1:0]     mem [RAM_BYTES];
  logic [OFF_W-1:0] idx;

  assign idx = off - OFF_W'(RAM_BASE);

  always_ff @(posedge clk) begin
    if (we && int'(idx) < RAM_BYTES) mem[idx] <= wdata;
  end

  assign rdata = (int'(idx) < RAM_BYTES) ? mem[idx] : '0;
endmodule

// File: rtl/pz_stack_ptr.sv
module pz_stack_ptr #(
  parameter int SP_W        = 7,
  parameter int PAGE_BYTES  = 128,
  parameter int STACK_BYTES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp
);
  localparam logic [SP_W-1:0] SP_TOP  = SP_W'(PAGE_BYTES - 1);
  localparam logic [SP_W-1:0] SP_BASE = SP_W'(PAGE_BYTES - STACK_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= SP_TOP;
    end else if (push && !pop) begin
      sp <= (sp == SP_BASE) ? SP_TOP : sp - 1'b1;
    end else if (pop && !push) begin
      sp <= (sp == SP_TOP) ? SP_BASE : sp + 1'b1;
    end
  end
endmodule

// File: rtl/pz_decoder.sv
module pz_decoder
  import pz_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int RAM_BASE    = 16,
  parameter int STACK_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic                          cpu_wr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          ext_en,
  input  logic [DATA_W-1:0]             ext_rdata,
  output logic                          tmr_sel,
  output logic                          tmr_reg,
  output logic                          tmr_wr,
  output logic [DATA_W-1:0]             tmr_wdata,
  input  logic [DATA_W-1:0]             tmr_rdata,
  input  logic [DATA_W-1:0]             pa_pin_in,
  output logic [DATA_W-1:0]             pa_pin_out,
  output logic [DATA_W-1:0]             pa_pin_oe,
  input  logic [DATA_W-1:0]             pb_pin_in,
  output logic [DATA_W-1:0]             pb_pin_out,
  output logic [DATA_W-1:0]             pb_pin_oe,
  input  logic                          sp_push,
  input  logic                          sp_pop,
  output logic [$clog2(PAGE_BYTES)-1:0] stack_ptr
);
  localparam int OFF_W     = $clog2(PAGE_BYTES);
  localparam int RAM_BYTES = PAGE_BYTES - RAM_BASE;
  localparam int NPORTS    = 2;

  region_e          region;
  logic             sub;
  logic [OFF_W-1:0] off;
  logic [DATA_W-1:0] ram_rd;

  logic [DATA_W-1:0] p_in  [NPORTS];
  logic [DATA_W-1:0] p_out [NPORTS];
  logic [DATA_W-1:0] p_oe  [NPORTS];
  logic [DATA_W-1:0] p_rd  [NPORTS];
  logic [DATA_W-1:0] p_ddr [NPORTS];

  pz_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .RAM_BASE(RAM_BASE)
  ) u_dec (
    .addr(cpu_addr), .region(region), .ext_en(ext_en), .sub(sub), .off(off)
  );

  assign p_in[0]    = pa_pin_in;
  assign p_in[1]    = pb_pin_in;
  assign pa_pin_out = p_out[0];
  assign pb_pin_out = p_out[1];
  assign pa_pin_oe  = p_oe[0];
  assign pb_pin_oe  = p_oe[1];

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic hit_sub;
    assign hit_sub = (int'(sub) == g);
    pz_port #(.W(DATA_W)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wdata  (cpu_wdata),
      .wr_dr  (cpu_wr && region == RG_PDATA && hit_sub),
      .wr_ddr (cpu_wr && region == RG_PDDR && hit_sub),
      .pin_in (p_in[g]),
      .pin_out(p_out[g]),
      .pin_oe (p_oe[g]),
      .rd_data(p_rd[g]),
      .ddr_q  (p_ddr[g])
    );
  end

  pz_ram #(
    .W(DATA_W), .OFF_W(OFF_W), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)
  ) u_ram (
    .clk(clk), .we(cpu_wr && region == RG_RAM), .off(off),
    .wdata(cpu_wdata), .rdata(ram_rd)
  );

  pz_stack_ptr #(
    .SP_W(OFF_W), .PAGE_BYTES(PAGE_BYTES), .STACK_BYTES(STACK_BYTES)
  ) u_sp (
    .clk(clk), .rst_n(rst_n), .push(sp_push), .pop(sp_pop), .sp(stack_ptr)
  );

  assign tmr_sel   = (region == RG_TMR);
  assign tmr_reg   = sub;
  assign tmr_wr    = tmr_sel && cpu_wr;
  assign tmr_wdata = cpu_wdata;

  always_comb begin
    case (region)
      RG_PDATA: cpu_rdata = p_rd[sub];
      RG_PDDR:  cpu_rdata = p_ddr[sub];
      RG_TMR:   cpu_rdata = tmr_rdata;
      RG_RAM:   cpu_rdata = ram_rd;
      default:  cpu_rdata = ext_rdata;
    endcase
  end
endmodule

// File: rtl/pz_decoder_chk.sv
module pz_decoder_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int SP_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              ext_en,
  input logic [DATA_W-1:0] ext_rdata,
  input logic              tmr_sel,
  input logic              tmr_wr,
  input logic [DATA_W-1:0] pa_pin_out,
  input logic [DATA_W-1:0] pa_pin_oe,
  input logic [DATA_W-1:0] pb_pin_out,
  input logic [DATA_W-1:0] pb_pin_oe,
  input logic              sp_push,
  input logic              sp_pop,
  input logic [SP_W-1:0]   stack_ptr
);
  p_page_ext_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:SP_W] != '0) |-> ext_en);

  p_ext_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |-> (cpu_rdata == ext_rdata));

  p_tmr_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |-> (tmr_sel && cpu_wr && !ext_en));

  p_ext_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ext_en) |=> ($stable(pa_pin_out) && $stable(pa_pin_oe) &&
                            $stable(pb_pin_out) && $stable(pb_pin_oe)));

  p_sp_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ptr[SP_W-1] == 1'b1);

  p_sp_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_push && !sp_pop && stack_ptr != 7'h40) |=> (stack_ptr == $past(stack_ptr) - 7'd1));
endmodule

bind pz_decoder pz_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W($clog2(PAGE_BYTES))) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .ext_en(ext_en), .ext_rdata(ext_rdata),
  .tmr_sel(tmr_sel), .tmr_wr(tmr_wr), .pa_pin_out(pa_pin_out),
  .pa_pin_oe(pa_pin_oe), .pb_pin_out(pb_pin_out), .pb_pin_oe(pb_pin_oe),
  .sp_push(sp_push), .sp_pop(sp_pop), .stack_ptr(stack_ptr)
);

// File: tb/pz_decoder_tb.sv
module pz_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        ext_en;
  logic [7:0]  ext_rdata = 8'hEE;
  logic        tmr_sel, tmr_reg, tmr_wr;
  logic [7:0]  tmr_wdata;
  logic [7:0]  tmr_rdata = 8'h77;
  logic [7:0]  pa_pin_in = 8'h5A, pb_pin_in = 8'hC3;
  logic [7:0]  pa_pin_out, pa_pin_oe, pb_pin_out, pb_pin_oe;
  logic        sp_push = 1'b0, sp_pop = 1'b0;
  logic [6:0]  stack_ptr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pz_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ext_en(ext_en),
    .ext_rdata(ext_rdata), .tmr_sel(tmr_sel), .tmr_reg(tmr_reg),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata),
    .pa_pin_in(pa_pin_in), .pa_pin_out(pa_pin_out), .pa_pin_oe(pa_pin_oe),
    .pb_pin_in(pb_pin_in), .pb_pin_out(pb_pin_out), .pb_pin_oe(pb_pin_oe),
    .sp_push(sp_push), .sp_pop(sp_pop), .stack_ptr(stack_ptr)
  );

  // {write, addr[12:0], wdata/unused, expected read}
  localparam logic [29:0] VEC [14] = '{
    {1'b1, 13'h0004, 8'hFF, 8'h00},  // R5 port A all outputs
    {1'b1, 13'h0000, 8'h3C, 8'h00},  // R4
    {1'b0, 13'h0000, 8'h00, 8'h3C},  // R4 R3 read A data
    {1'b0, 13'h0004, 8'h00, 8'hFF},  // R5 read A direction
    {1'b1, 13'h0005, 8'hF0, 8'h00},  // R5 port B upper outputs
    {1'b1, 13'h0001, 8'hA5, 8'h00},  // R4
    {1'b0, 13'h0001, 8'h00, 8'hA3},  // R6 mix A0 | 03
    {1'b1, 13'h0010, 8'h11, 8'h00},  // R9 lowest RAM byte
    {1'b1, 13'h007F, 8'h99, 8'h00},  // R9 highest RAM byte
    {1'b0, 13'h0010, 8'h00, 8'h11},  // R9 R3
    {1'b0, 13'h007F, 8'h00, 8'h99},  // R9 R3
    {1'b0, 13'h0008, 8'h00, 8'h77},  // R8 timer read
    {1'b0, 13'h0002, 8'h00, 8'hEE},  // R2 hole
    {1'b0, 13'h0080, 8'h00, 8'hEE}   // R2 above page zero
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [12:0] a, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    #1 check(req, cpu_rdata, exp);
  endtask

  task automatic sp_step(input bit pu, input bit po, input logic [6:0] exp);
    @(negedge clk);
    sp_push = pu; sp_pop = po;
    @(negedge clk);
    sp_push = 1'b0; sp_pop = 1'b0;
    check("R11 stack_ptr", stack_ptr, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state, R11 reset pointer
    check("R7 pa_pin_oe", pa_pin_oe, 0);
    check("R7 pb_pin_oe", pb_pin_oe, 0);
    check("R7 pa_pin_out", pa_pin_out, 0);
    check("R11 reset", stack_ptr, 7'h7F);
    rd("R6 R7 input pins", 13'h0000, 8'h5A);

    // R1 sweep 0..255
    for (int a = 0; a < 256; a++) begin
      bit exp_int;
      exp_int = (a < 128) && (a >= 16 || a == 0 || a == 1 || a == 4 ||
                              a == 5 || a == 8 || a == 9);
      @(negedge clk);
      cpu_addr = 13'(a);
      #1 check("R1 ext_en", ext_en, exp_int ? 0 : 1);
    end
    @(negedge clk);
    cpu_addr = 13'h1FFF;
    #1 check("R1 ext_en top", ext_en, 1);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][29]) wr(VEC[i][28:16], VEC[i][15:8]);
      else rd("R2-vector", VEC[i][28:16], VEC[i][7:0]);
    end
    check("R4 pa_pin_out", pa_pin_out, 8'h3C);
    check("R5 pb_pin_oe", pb_pin_oe, 8'hF0);

    // R3 internal reads ignore a conflicting external bus
    ext_rdata = 8'h11 ^ 8'hFF;
    rd("R3 ram vs ext", 13'h0010, 8'h11);
    ext_rdata = 8'h00;
    rd("R3 ddr vs ext", 13'h0004, 8'hFF);
    ext_rdata = 8'hEE;

    // R6 pin change seen only on input bits
    pb_pin_in = 8'h3C;
    rd("R6 port B mix", 13'h0001, 8'hAC);

    // R10 external writes change nothing internal
    wr(13'h0080, 8'h00);
    wr(13'h0002, 8'h00);
    wr(13'h0090, 8'h00);
    check("R10 pa_pin_out", pa_pin_out, 8'h3C);
    rd("R10 ram", 13'h0010, 8'h11);

    // R8 timer strobes
    @(negedge clk);
    cpu_addr = 13'h0009; cpu_wr = 1'b1; cpu_wdata = 8'h42;
    #1;
    check("R8 tmr_sel", tmr_sel, 1);
    check("R8 tmr_reg", tmr_reg, 1);
    check("R8 tmr_wr", tmr_wr, 1);
    check("R8 tmr_wdata", tmr_wdata, 8'h42);
    @(negedge clk);
    cpu_addr = 13'h0003;
    #1 check("R8 tmr_wr hole", tmr_wr, 0);
    cpu_addr = 13'h0108;
    #1 check("R8 tmr_sel ext", tmr_sel, 0);
    cpu_wr = 1'b0;

    // R11 stack walk and wraps
    sp_step(1, 0, 7'h7E);
    sp_step(0, 1, 7'h7F);
    sp_step(0, 1, 7'h40);
    sp_step(1, 0, 7'h7F);
    sp_step(1, 1, 7'h7F);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule